// File: doc/BRIEF.md
# Real-Time Calendar Counter Chain

This block keeps time of day and calendar date in eight plain binary counters: hundredths, seconds, minutes, hours, day of week, date, month and year. It is driven by a one-cycle enable that pulses at the crystal rate. A fractional prescaler turns that rate into a 100 Hz tick. Four power-of-two crystal rates are supported. A command word starts and stops the count, selects the crystal rate, switches between 12-hour and 24-hour hour format, and selects a test mode in which every crystal pulse advances the hundredths counter.

Software reaches the counters through a small register port. Reading the hundredths counter returns its live value and copies every other counter into a holding snapshot. Reads of the other counters then return that snapshot, so a multi-byte time read cannot tear across a carry. A tick that arrives during a read or write strobe is kept and applied once the strobe ends.

Top module: `rtc_calendar_chain`

## Requirements
- R1: After reset all counters are zero except date and month, which are 1. The count is stopped, the rate select is 0 and the hour format is 12-hour, so the hours register (address 3) reads 0x0C.
- R2: The command word sits at address 8. Bit 0 is run, bit 1 is test, bit 2 selects 24-hour format, and bits 5:4 are the rate select. With rate select 0 (32768 Hz) the first tick comes on the 328th crystal pulse after run is set. Exactly 100 ticks come from 32768 pulses. The prescaler restarts from zero whenever run is 0.
- R3: With rate select 1 (1048576 Hz) the first tick comes on the 10486th crystal pulse and not on the 10485th. Rate selects 2 and 3 give 2097152 Hz and 4194304 Hz.
- R4: While run is 0, crystal pulses change no counter.
- R5: While run and test are both 1, each crystal pulse advances the hundredths counter by exactly one.
- R6: The counters wrap in binary at their limits. Hundredths runs 0–99, seconds and minutes 0–59, hours 0–23, day of week 0–6, month 1–12 and year 0–99. The last hundredth of 23:59:59 on 31 December of year 99 rolls every counter over, and day of week goes from 6 to 0.
- R7: The date runs 1 to the length of the current month. April has 30 days. February has 29 days when the year is a multiple of 4 and 28 days otherwise.
- R8: In 12-hour format the hours register reads 1–12 in bits 3:0, with bit 7 set for PM. A write in that format takes the same encoding, where 12 with bit 7 clear means midnight. The stored time does not change when the format changes.
- R9: In 24-hour format the hours register reads and writes 0–23 in bits 4:0.
- R10: Addresses 0 to 7 hold hundredths, seconds, minutes, hours, day of week, date, month and year. A read of address 0 returns live hundredths and captures all other counters. Reads of addresses 1 to 7 return the captured values until address 0 is read again. Read data updates one clock after the read strobe rises and holds until the next read.
- R11: Bits above each counter's width read as 0 and are ignored on write. The counter widths are 7, 6, 6, 5, 3, 5, 4 and 7 bits for addresses 0 to 7. The command word and addresses 9 to 15 read as 0. A write to addresses 9 to 15 changes nothing.
- R12: A tick that arrives while a read or write strobe is high is applied after the strobe falls. Counters do not change during a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One-cycle pulse per crystal period |
| rd_stb | input | 1 | Read strobe, level; the access is taken on its rising edge |
| wr_en | input | 1 | One-cycle write pulse |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |

## Verification
The assertions assume that the rate-select and test bits change only while the count is stopped. They also assume that write pulses last a single cycle and that read strobes are level signals. The range checks on advancing counters hold only for fields that move, because software may load out-of-range values. The directed stimulus follows these rules. It stops the count before it loads time or changes mode. It places crystal pulses only where a tick's cycle is known, and it idles for a few cycles before each read, so no read strobe meets a tick except in the one scenario built for that case.

// File: rtl/rtc_cal_pkg.sv
// Shared types, field layout and calendar helper functions for the
// calendar counter chain. Assumes plain binary storage of every field.
package rtc_cal_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_CENTI = 4'd0;
    localparam logic [ADDR_W-1:0] A_SEC   = 4'd1;
    localparam logic [ADDR_W-1:0] A_MIN   = 4'd2;
    localparam logic [ADDR_W-1:0] A_HOUR  = 4'd3;
    localparam logic [ADDR_W-1:0] A_DOW   = 4'd4;
    localparam logic [ADDR_W-1:0] A_DATE  = 4'd5;
    localparam logic [ADDR_W-1:0] A_MON   = 4'd6;
    localparam logic [ADDR_W-1:0] A_YEAR  = 4'd7;
    localparam logic [ADDR_W-1:0] A_CMD   = 4'd8;

    // Command word bit positions
    localparam int CMD_RUN_BIT  = 0;
    localparam int CMD_TEST_BIT = 1;
    localparam int CMD_H24_BIT  = 2;
    localparam int CMD_RATE_LSB = 4;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] mon;
        logic [4:0] date;
        logic [2:0] dow;
        logic [4:0] hour;   // always held as 0..23
        logic [5:0] min;
        logic [5:0] sec;
        logic [6:0] centi;
    } rtc_time_t;

    localparam rtc_time_t RTC_TIME_RESET = '{
        year: 7'd0, mon: 4'd1, date: 5'd1, dow: 3'd0,
        hour: 5'd0, min: 6'd0, sec: 6'd0, centi: 7'd0
    };

    // Length of a month; every fourth year has a 29-day February
    function automatic logic [4:0] days_in_month(input logic [3:0] mon,
                                                 input logic [6:0] year);
        case (mon)
            4'd2:                   return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                return 5'd31;
        endcase
    endfunction

    // Present a 0..23 hour in the selected register format
    function automatic logic [7:0] hour_to_reg(input logic [4:0] h24,
                                               input logic mode24);
        logic [4:0] h;
        logic       pm;
        if (mode24) return {3'b000, h24};
        pm = (h24 >= 5'd12);
        h  = pm ? (h24 - 5'd12) : h24;
        if (h == 5'd0) h = 5'd12;
        return {pm, 2'b00, h};
    endfunction

    // Convert a written hours byte into the 0..23 stored form
    function automatic logic [4:0] hour_from_reg(input logic [7:0] d,
                                                 input logic mode24);
        logic [4:0] base;
        if (mode24) return d[4:0];
        base = (d[3:0] == 4'd12) ? 5'd0 : {1'b0, d[3:0]};
        return d[7] ? (base + 5'd12) : base;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Fractional prescaler: turns crystal-rate enable pulses into a 100 Hz
// tick. A phase accumulator adds SUB_HZ per pulse and wraps at the
// selected crystal rate, giving SUB_HZ pulses per second on average;
// a modulo-TICK_DIV counter then gives the tick. In test mode every
// crystal pulse is a tick. Assumes rate and test change only while stopped.
module rtc_prescaler #(
    parameter int OSC_BASE_HZ = 32768,
    parameter int SUB_HZ      = 4000,
    parameter int TICK_DIV    = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       run,
    input  logic       test,
    input  logic [1:0] rate_sel,
    output logic       tick
);
    localparam int MAX_HZ = OSC_BASE_HZ * 128;
    localparam int ACC_W  = $clog2(MAX_HZ) + 1;
    localparam int DIV_W  = $clog2(TICK_DIV);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] rate_hz;
    logic [DIV_W-1:0] div_q;
    logic             sub_pulse;

    // Select the crystal rate: base, or base times 32, 64 or 128
    always_comb begin
        case (rate_sel)
            2'd0:    rate_hz = ACC_W'(OSC_BASE_HZ);
            2'd1:    rate_hz = ACC_W'(OSC_BASE_HZ) << 5;
            2'd2:    rate_hz = ACC_W'(OSC_BASE_HZ) << 6;
            default: rate_hz = ACC_W'(OSC_BASE_HZ) << 7;
        endcase
        acc_sum   = acc_q + ACC_W'(SUB_HZ);
        sub_pulse = (acc_sum >= rate_hz);
    end

    // Advance the accumulator and tick divider on each crystal pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            acc_q <= '0;
            div_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (osc_en) begin
                if (test) begin
                    tick <= 1'b1;
                end else begin
                    acc_q <= sub_pulse ? (acc_sum - rate_hz) : acc_sum;
                    if (sub_pulse) begin
                        if (div_q == DIV_W'(TICK_DIV - 1)) begin
                            div_q <= '0;
                            tick  <= 1'b1;
                        end else begin
                            div_q <= div_q + 1'b1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rtc_tick_hold.sv
// Defers a tick that meets a bus strobe until the strobe ends, so a
// counter never moves while being read or written. Holds one tick;
// strobes are assumed shorter than one tick period.
module rtc_tick_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic hold,
    output logic adv
);
    logic pending_q;

    assign adv = (tick | pending_q) & ~hold & run;

    // Remember a tick that could not be applied this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= 1'b0;
        else        pending_q <= run & (tick | pending_q) & hold;
    end

endmodule

// File: rtl/rtc_time_chain.sv
// The eight cascaded time and calendar counters. A write loads one
// field (unused bits dropped); otherwise an advance steps hundredths
// and ripples carries up to the year. Wrap tests use >= so software
// loads of out-of-range values recover on the next carry.
module rtc_time_chain
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mode24,
    output rtc_time_t         now_t
);
    rtc_time_t now_q;
    rtc_time_t nxt;
    logic      c_wrap, s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap;
    logic      to_sec, to_min, to_hour, to_day, to_mon, to_year;

    // Carry network and next value for one hundredth step
    always_comb begin
        c_wrap  = (now_q.centi >= 7'd99);
        s_wrap  = (now_q.sec   >= 6'd59);
        m_wrap  = (now_q.min   >= 6'd59);
        h_wrap  = (now_q.hour  >= 5'd23);
        d_wrap  = (now_q.date  >= days_in_month(now_q.mon, now_q.year));
        mo_wrap = (now_q.mon   >= 4'd12);
        to_sec  = c_wrap;
        to_min  = to_sec  & s_wrap;
        to_hour = to_min  & m_wrap;
        to_day  = to_hour & h_wrap;
        to_mon  = to_day  & d_wrap;
        to_year = to_mon  & mo_wrap;

        nxt       = now_q;
        nxt.centi = c_wrap ? 7'd0 : now_q.centi + 7'd1;
        if (to_sec)  nxt.sec  = s_wrap ? 6'd0 : now_q.sec + 6'd1;
        if (to_min)  nxt.min  = m_wrap ? 6'd0 : now_q.min + 6'd1;
        if (to_hour) nxt.hour = h_wrap ? 5'd0 : now_q.hour + 5'd1;
        if (to_day) begin
            nxt.dow  = (now_q.dow >= 3'd6) ? 3'd0 : now_q.dow + 3'd1;
            nxt.date = d_wrap ? 5'd1 : now_q.date + 5'd1;
        end
        if (to_mon)  nxt.mon  = mo_wrap ? 4'd1 : now_q.mon + 4'd1;
        if (to_year) nxt.year = (now_q.year >= 7'd99) ? 7'd0 : now_q.year + 7'd1;
    end

    // Load a field on write, otherwise step on an advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= RTC_TIME_RESET;
        end else if (wr_en) begin
            case (addr)
                A_CENTI: now_q.centi <= wr_data[6:0];
                A_SEC:   now_q.sec   <= wr_data[5:0];
                A_MIN:   now_q.min   <= wr_data[5:0];
                A_HOUR:  now_q.hour  <= hour_from_reg(wr_data, mode24);
                A_DOW:   now_q.dow   <= wr_data[2:0];
                A_DATE:  now_q.date  <= wr_data[4:0];
                A_MON:   now_q.mon   <= wr_data[3:0];
                A_YEAR:  now_q.year  <= wr_data[6:0];
                default: ;
            endcase
        end else if (adv) begin
            now_q <= nxt;
        end
    end

    assign now_t = now_q;

endmodule

// File: rtl/rtc_read_port.sv
// Read side of the register port. On the rising edge of the read
// strobe it registers the addressed byte; an access to the hundredths
// address also copies all counters into the snapshot that later reads
// of the other counters return.
module rtc_read_port
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] addr,
    input  rtc_time_t         now_t,
    input  logic              mode24,
    output logic [DATA_W-1:0] rd_data
);
    rtc_time_t         snap_q;
    logic              rd_q;
    logic [DATA_W-1:0] snap_byte;

    // Format the addressed snapshot field, zero-filling unused bits
    always_comb begin
        case (addr)
            A_SEC:   snap_byte = {2'b00, snap_q.sec};
            A_MIN:   snap_byte = {2'b00, snap_q.min};
            A_HOUR:  snap_byte = hour_to_reg(snap_q.hour, mode24);
            A_DOW:   snap_byte = {5'b00000, snap_q.dow};
            A_DATE:  snap_byte = {3'b000, snap_q.date};
            A_MON:   snap_byte = {4'b0000, snap_q.mon};
            A_YEAR:  snap_byte = {1'b0, snap_q.year};
            default: snap_byte = '0;
        endcase
    end

    // Capture read data and the snapshot on a new read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            snap_q  <= RTC_TIME_RESET;
            rd_data <= '0;
        end else begin
            rd_q <= rd_stb;
            if (rd_stb && !rd_q) begin
                if (addr == A_CENTI) begin
                    snap_q  <= now_t;
                    rd_data <= {1'b0, now_t.centi};
                end else begin
                    rd_data <= snap_byte;
                end
            end
        end
    end

endmodule

// File: rtl/rtc_calendar_chain.sv
// Top of the calendar counter chain: command word, prescaler, tick
// deferral, counter chain and read port. Assumes osc_en pulses for one
// cycle per crystal period and write pulses last one cycle.
module rtc_calendar_chain
    import rtc_cal_pkg::*;
#(
    parameter int OSC_BASE_HZ = 32768,
    parameter int SUB_HZ      = 4000,
    parameter int TICK_DIV    = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic              rd_stb,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic       cmd_run, cmd_test, cmd_h24;
    logic [1:0] cmd_rate;
    logic       tick_raw, tick_adv;
    rtc_time_t  now_t;

    // Command word: write-only control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_run  <= 1'b0;
            cmd_test <= 1'b0;
            cmd_h24  <= 1'b0;
            cmd_rate <= 2'd0;
        end else if (wr_en && addr == A_CMD) begin
            cmd_run  <= wr_data[CMD_RUN_BIT];
            cmd_test <= wr_data[CMD_TEST_BIT];
            cmd_h24  <= wr_data[CMD_H24_BIT];
            cmd_rate <= wr_data[CMD_RATE_LSB +: 2];
        end
    end

    rtc_prescaler #(
        .OSC_BASE_HZ (OSC_BASE_HZ),
        .SUB_HZ      (SUB_HZ),
        .TICK_DIV    (TICK_DIV)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .run      (cmd_run),
        .test     (cmd_test),
        .rate_sel (cmd_rate),
        .tick     (tick_raw)
    );

    rtc_tick_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cmd_run),
        .tick  (tick_raw),
        .hold  (rd_stb | wr_en),
        .adv   (tick_adv)
    );

    rtc_time_chain u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (tick_adv),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .mode24  (cmd_h24),
        .now_t   (now_t)
    );

    rtc_read_port u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .addr    (addr),
        .now_t   (now_t),
        .mode24  (cmd_h24),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/rtc_calendar_chk.sv
// Property checker for the calendar counter chain, bound to the top.
module rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic              wr_en,
    input logic              run,
    input logic              test,
    input logic              tick,
    input logic              adv,
    input rtc_time_t         now_t,
    input logic [DATA_W-1:0] rd_data
);
    logic rd_prev;

    // Track the strobe to find read starts
    always_ff @(posedge clk) begin
        if (!rst_n) rd_prev <= 1'b0;
        else        rd_prev <= rd_stb;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !test && !$past(test)) |=> !tick);

    // R4
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> $stable(now_t));

    // R6
    centi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (now_t.centi <= 7'd99));

    // R7
    date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ((now_t.date == $past(now_t.date)) ||
                 (now_t.date >= 5'd1 && now_t.date <= 5'd31)));

    // R6
    month_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ((now_t.mon == $past(now_t.mon)) ||
                 (now_t.mon >= 4'd1 && now_t.mon <= 4'd12)));

    // R10
    rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && !rd_prev) |=> $stable(rd_data));

    // R12
    read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_en) |=> $stable(now_t));

endmodule

bind rtc_calendar_chain rtc_calendar_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb),
    .wr_en   (wr_en),
    .run     (cmd_run),
    .test    (cmd_test),
    .tick    (tick_raw),
    .adv     (tick_adv),
    .now_t   (now_t),
    .rd_data (rd_data)
);

// File: tb/rtc_calendar_chain_tb.sv
// Directed bench for the calendar counter chain.
module rtc_calendar_chain_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rtc_calendar_chain u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_en  (osc_en),
        .rd_stb  (rd_stb),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_stb = 1'b1;
        @(negedge clk);
        v = rd_data;
        rd_stb = 1'b0;
    endtask

    // Read address 0 to refresh the snapshot, then the wanted field
    task automatic rd_snap(input logic [3:0] a, output logic [7:0] v);
        logic [7:0] tmp;
        rd(4'd0, tmp);
        rd(a, v);
    endtask

    task automatic osc(input int n);
        @(negedge clk);
        osc_en = 1'b1;
        repeat (n) @(negedge clk);
        osc_en = 1'b0;
        idle(4);
    endtask

    task automatic cmd(input bit run, input bit test, input bit h24, input logic [1:0] rate);
        wr(4'd8, {2'b00, rate, 1'b0, h24, test, run});
    endtask

    // Load the last hundredth of a day in 24-hour form, then step once
    task automatic step_day_end(input logic [7:0] yr, input logic [7:0] mo,
                                input logic [7:0] dt, input logic [7:0] dw,
                                input logic [7:0] hr);
        cmd(0, 1, 1, 2'd0);
        wr(4'd7, yr); wr(4'd6, mo); wr(4'd5, dt); wr(4'd4, dw);
        wr(4'd3, hr); wr(4'd2, 8'd59); wr(4'd1, 8'd59); wr(4'd0, 8'd99);
        cmd(1, 1, 1, 2'd0);
        osc(1);
        cmd(0, 1, 1, 2'd0);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(4'd0, v); chk("R1 hundredths", v, 8'd0);
        rd(4'd1, v); chk("R1 seconds", v, 8'd0);
        rd(4'd3, v); chk("R1 hours 12h", v, 8'h0C);
        rd(4'd5, v); chk("R1 date", v, 8'd1);
        rd(4'd6, v); chk("R1 month", v, 8'd1);
    endtask

    task automatic t_stop;
        logic [7:0] v;
        osc(500);
        rd(4'd0, v); chk("R4 stopped hundredths", v, 8'd0);
    endtask

    task automatic t_rate0;
        logic [7:0] v;
        cmd(1, 0, 1, 2'd0);
        osc(327);
        rd(4'd0, v); chk("R2 no tick at 327", v, 8'd0);
        osc(1);
        rd(4'd0, v); chk("R2 tick at 328", v, 8'd1);
        osc(32768 - 328);
        rd(4'd0, v); chk("R2 one second hundredths", v, 8'd0);
        rd(4'd1, v); chk("R2 one second seconds", v, 8'd1);
        cmd(0, 0, 1, 2'd0);
    endtask

    task automatic t_rate1;
        logic [7:0] v;
        wr(4'd0, 8'd0);
        cmd(1, 0, 1, 2'd1);
        osc(10485);
        rd(4'd0, v); chk("R3 no tick at 10485", v, 8'd0);
        osc(1);
        rd(4'd0, v); chk("R3 tick at 10486", v, 8'd1);
        cmd(0, 0, 1, 2'd0);
    endtask

    task automatic t_test;
        logic [7:0] v;
        wr(4'd0, 8'd10);
        cmd(1, 1, 1, 2'd0);
        osc(7);
        cmd(0, 1, 1, 2'd0);
        rd(4'd0, v); chk("R5 test mode count", v, 8'd17);
    endtask

    task automatic t_hold;
        logic [7:0] v;
        cmd(1, 1, 1, 2'd0);
        @(negedge clk);
        addr = 4'd1; rd_stb = 1'b1;
        idle(2);
        osc_en = 1'b1;
        @(negedge clk);
        osc_en = 1'b0;
        idle(4);
        rd_stb = 1'b0;
        idle(4);
        cmd(0, 1, 1, 2'd0);
        rd(4'd0, v); chk("R12 deferred tick kept", v, 8'd18);
    endtask

    task automatic t_rollover;
        logic [7:0] v;
        step_day_end(8'd99, 8'd12, 8'd31, 8'd6, 8'd23);
        rd(4'd0, v); chk("R6 hundredths wrap", v, 8'd0);
        rd(4'd1, v); chk("R6 seconds wrap", v, 8'd0);
        rd(4'd2, v); chk("R6 minutes wrap", v, 8'd0);
        rd(4'd3, v); chk("R6 hours wrap", v, 8'd0);
        rd(4'd4, v); chk("R6 day of week wrap", v, 8'd0);
        rd(4'd5, v); chk("R6 date wrap", v, 8'd1);
        rd(4'd6, v); chk("R6 month wrap", v, 8'd1);
        rd(4'd7, v); chk("R6 year wrap", v, 8'd0);
    endtask

    task automatic t_leap;
        logic [7:0] v;
        step_day_end(8'd23, 8'd2, 8'd28, 8'd1, 8'd23);
        rd_snap(4'd5, v); chk("R7 common Feb end date", v, 8'd1);
        rd(4'd6, v);      chk("R7 common Feb end month", v, 8'd3);
        step_day_end(8'd24, 8'd2, 8'd28, 8'd1, 8'd23);
        rd_snap(4'd5, v); chk("R7 leap Feb 29", v, 8'd29);
        rd(4'd6, v);      chk("R7 leap Feb month", v, 8'd2);
        step_day_end(8'd24, 8'd2, 8'd29, 8'd1, 8'd23);
        rd_snap(4'd5, v); chk("R7 leap Feb end date", v, 8'd1);
        rd(4'd6, v);      chk("R7 leap Feb end month", v, 8'd3);
        step_day_end(8'd24, 8'd4, 8'd30, 8'd1, 8'd23);
        rd_snap(4'd6, v); chk("R7 April end month", v, 8'd5);
    endtask

    task automatic t_12h;
        logic [7:0] v;
        cmd(0, 1, 0, 2'd0);
        wr(4'd3, 8'h0B); wr(4'd2, 8'd59); wr(4'd1, 8'd59); wr(4'd0, 8'd99);
        cmd(1, 1, 0, 2'd0);
        osc(1);
        cmd(0, 1, 0, 2'd0);
        rd_snap(4'd3, v); chk("R8 noon reads 12 PM", v, 8'h8C);
        wr(4'd3, 8'h0C);
        cmd(0, 1, 1, 2'd0);
        rd_snap(4'd3, v); chk("R8 12 AM is midnight", v, 8'd0);
        cmd(0, 1, 0, 2'd0);
        wr(4'd3, 8'h87);
        cmd(0, 1, 1, 2'd0);
        rd_snap(4'd3, v); chk("R8 7 PM as 24h", v, 8'd19);
        cmd(0, 1, 0, 2'd0);
        rd_snap(4'd3, v); chk("R8 7 PM readback", v, 8'h87);
    endtask

    task automatic t_24h;
        logic [7:0] v;
        cmd(0, 1, 1, 2'd0);
        wr(4'd3, 8'd13); wr(4'd2, 8'd59); wr(4'd1, 8'd59); wr(4'd0, 8'd99);
        cmd(1, 1, 1, 2'd0);
        osc(1);
        cmd(0, 1, 1, 2'd0);
        rd_snap(4'd3, v); chk("R9 hour carry 24h", v, 8'd14);
        wr(4'd3, 8'hF7);
        rd_snap(4'd3, v); chk("R9 R11 hour write masked", v, 8'd23);
    endtask

    task automatic t_snapshot;
        logic [7:0] v;
        cmd(0, 1, 1, 2'd0);
        wr(4'd1, 8'd5); wr(4'd0, 8'd99);
        cmd(1, 1, 1, 2'd0);
        rd(4'd0, v); chk("R10 live hundredths", v, 8'd99);
        osc(1);
        rd(4'd1, v); chk("R10 seconds from snapshot", v, 8'd5);
        rd(4'd0, v); chk("R10 hundredths after carry", v, 8'd0);
        rd(4'd1, v); chk("R10 refreshed seconds", v, 8'd6);
        cmd(0, 1, 1, 2'd0);
    endtask

    task automatic t_unused;
        logic [7:0] v;
        wr(4'd1, 8'hC5);
        rd_snap(4'd1, v); chk("R11 seconds high bits", v, 8'd5);
        wr(4'd7, 8'hE3);
        rd_snap(4'd7, v); chk("R11 year high bit", v, 8'h63);
        rd(4'd8, v);  chk("R11 command reads 0", v, 8'd0);
        rd(4'd15, v); chk("R11 unused address", v, 8'd0);
        wr(4'd12, 8'h55);
        rd_snap(4'd1, v); chk("R11 unused write ignored", v, 8'd5);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_stop;
        t_rate0;
        t_rate1;
        t_test;
        t_hold;
        t_rollover;
        t_leap;
        t_12h;
        t_24h;
        t_snapshot;
        t_unused;
        finish_run;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R1-scope run actual=timeout expected=completion");
        finish_run;
    end

endmodule